// File: doc/BRIEF.md
# Linked page-table address translator

This block sits between a trace-buffer writer and system memory. It takes a linear input address and produces a physical address. The lookup uses a chain of 4 KB translation tables held in memory. Every table covers exactly one 1 MB window of input space. Tables are joined by a forward link and a backward link stored inside each table page, so there is no multi-level walk. The block keeps its position in the chain: the base of the table it last reached and that table's window number. When an access falls in another window, the block steps along the links one table at a time until it reaches the right one. It then reads the single entry that names the data page.

A pass-through mode forwards every address unchanged. Software programs the mode and the two base addresses while the unit is stopped, and then sets enable. Clearing enable lets the request in flight finish, after which the unit reports ready again. Lookup failures consume the upstream request without a downstream write, pulse a fault output, and set a sticky error flag.

Each request moves through these states:

- **S_OFF**: disabled and idle.
- **S_WAIT**: waits for a request. It returns to S_OFF when enable is low, or goes to S_CHK when a request arrives, capturing its address.
- **S_CHK**: picks the path.
  - In pass-through mode it goes to S_SEND.
  - In translate mode, an address below the base goes to S_FAULT.
  - Otherwise it goes to S_WALK. On the first access after enable it first loads the table base with window 0.
- **S_WALK**: goes to S_EREQ if the window matches the cached one, and to S_LREQ if not.
- **S_LREQ → S_LWAIT**: reads a link. A valid link returns to S_WALK with the window stepped by one. An invalid link goes to S_FAULT.
- **S_EREQ → S_EWAIT**: reads the entry. A valid entry goes to S_SEND. An invalid entry goes to S_FAULT.
- **S_SEND**: presents the downstream request and returns to S_WAIT when accepted.
- **S_FAULT**: lasts one cycle, then returns to S_WAIT.

Top module: `lpt_xlat`

## Requirements
- R1: After reset, the status register reads 1 (bit0 ready = 1, bit1 error = 0). Control reads 0, and no downstream or memory request is active.
- R2: Register map on `reg_addr`:
  - 0 is control, with bit0 enable.
  - 1 is mode, with bit0 = 1 for translate and 0 for pass-through.
  - 2 is status.
  - 3 is input base; bits 31:20 are kept.
  - 4 is table base; bits 39:12 are kept.

  In pass-through, `dn_addr` is `up_addr` zero-extended and `dn_data` equals `up_data`. No table read is made and the base registers have no effect, even for an address below the input base.
- R3: In translate mode, the window number is (input address − input base) >> 20 and the entry index is input bits 19:12. The entry is read from table base + index × 8. The output is entry bits 39:12 followed by input bits 11:0.
- R4: When the target window is above the cached one, the block reads slot 511 (offset 0xFF8) of the current table. It takes bits 39:12 of that link as the next table and repeats until the window matches.
- R5: When the target window is below the cached one, the block reads slot 510 (offset 0xFF0) instead and steps down in the same way.
- R6: The table position is cached. Another access in the same window makes exactly one memory read, the entry itself. The first access after enable starts again from the table base at window 0.
- R7: An entry whose bit0 is 0 gives a fault: the upstream request is accepted, `xl_fault` pulses, no downstream request is issued, and status bit1 becomes 1.
- R8: A link whose bit0 is 0 gives a fault in the same way. The cached position stays at the last table reached.
- R9: In translate mode, an input address below the input base gives a fault without any memory read.
- R10: Status bit1 is sticky. Writing 1 to status bit1 clears it, and writing 0 leaves it set.
- R11: Writes to mode, input base and table base take effect only while enable is 0 and the unit is ready. Otherwise they are ignored, as register reads show.
- R12: Status bit0 is 0 while enabled. When enable is cleared during a request, that request completes downstream, then bit0 returns to 1. No memory read is pending while ready.
- R13: At most one table read is outstanding: `mem_req` is never raised again before `mem_rvalid` answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for `reg_addr` |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request consumed (sent or faulted) |
| up_addr | input | IA_W | Linear input address |
| up_data | input | DATA_W | Write data, held until accepted |
| mem_req | output | 1 | Table read request, one cycle |
| mem_addr | output | PA_W | Table read address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 64 | Table entry or link |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream ready |
| dn_addr | output | PA_W | Translated address |
| dn_data | output | DATA_W | Forwarded write data |
| xl_fault | output | 1 | One-cycle pulse when a request fails |

## Verification
The translator is exercised with a three-table chain in memory, using these access patterns:

- **Window-0 hits**: show the entry index and page offset being combined.
- **Repeated access in one window**: separates a cached position from one that walks again.
- **One-step and multi-step climbs**: show the forward link being followed more than once.
- **Descent across two windows back to window 0**: separates the backward link from the forward one.

A scoreboard of expected table-read addresses catches any extra, missing or misordered read. Invalid entries, an invalid link at the end of the chain and an address below the base are each used to separate the three fault causes. Pass-through accesses with addresses both above and below the base show that the bases have no effect in that mode.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int PG_SH  = 12;
    localparam int WIN_SH = 20;
    localparam int IDX_W  = WIN_SH - PG_SH;
    localparam int ENT_W  = 64;

    localparam logic [8:0] SLOT_PREV = 9'd510;
    localparam logic [8:0] SLOT_NEXT = 9'd511;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_MODE = 3'd1;
    localparam logic [2:0] RA_STAT = 3'd2;
    localparam logic [2:0] RA_INB  = 3'd3;
    localparam logic [2:0] RA_TBL  = 3'd4;

    typedef enum logic [3:0] {
        S_OFF,
        S_WAIT,
        S_CHK,
        S_WALK,
        S_LREQ,
        S_LWAIT,
        S_EREQ,
        S_EWAIT,
        S_SEND,
        S_FAULT
    } lpt_state_e;
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int IA_W  = 32,
    parameter int PA_W  = 40,
    parameter int REG_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [2:0]              reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    input  logic                    fsm_idle,
    input  logic                    fault_set,
    output logic                    cfg_en,
    output logic                    cfg_xl,
    output logic [IA_W-WIN_SH-1:0]  cfg_base_hi,
    output logic [PA_W-PG_SH-1:0]   cfg_tbl_pg,
    output logic                    sts_err
);
    logic cfg_open;
    logic unused_wd;

    assign cfg_open  = !cfg_en && fsm_idle;
    assign unused_wd = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en      <= 1'b0;
            cfg_xl      <= 1'b0;
            cfg_base_hi <= '0;
            cfg_tbl_pg  <= '0;
            sts_err     <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == RA_CTRL) begin
                cfg_en <= reg_wdata[0];
            end
            if (reg_wr && cfg_open) begin
                if (reg_addr == RA_MODE) cfg_xl      <= reg_wdata[0];
                if (reg_addr == RA_INB)  cfg_base_hi <= reg_wdata[IA_W-1:WIN_SH];
                if (reg_addr == RA_TBL)  cfg_tbl_pg  <= reg_wdata[PA_W-1:PG_SH];
            end
            if (fault_set) begin
                sts_err <= 1'b1;
            end else if (reg_wr && reg_addr == RA_STAT && reg_wdata[1]) begin
                sts_err <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = REG_W'(cfg_en);
            RA_MODE: reg_rdata = REG_W'(cfg_xl);
            RA_STAT: reg_rdata = REG_W'({sts_err, fsm_idle});
            RA_INB:  reg_rdata = REG_W'({cfg_base_hi, {WIN_SH{1'b0}}});
            RA_TBL:  reg_rdata = REG_W'({cfg_tbl_pg, {PG_SH{1'b0}}});
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lpt_window.sv
module lpt_window
    import lpt_pkg::*;
#(
    parameter int IA_W  = 32,
    localparam int WIN_W = IA_W - WIN_SH
) (
    input  logic [IA_W-1:0]  in_addr,
    input  logic [WIN_W-1:0] base_hi,
    output logic             below,
    output logic [WIN_W-1:0] win,
    output logic [IDX_W-1:0] idx
);
    logic [WIN_W-1:0] addr_hi;

    assign addr_hi = in_addr[IA_W-1:WIN_SH];
    assign below   = addr_hi < base_hi;
    assign win     = addr_hi - base_hi;
    assign idx     = in_addr[WIN_SH-1:PG_SH];
endmodule

// File: rtl/lpt_fsm.sv
module lpt_fsm
    import lpt_pkg::*;
#(
    parameter int IA_W  = 32,
    parameter int PA_W  = 40,
    localparam int WIN_W = IA_W - WIN_SH,
    localparam int PG_W  = PA_W - PG_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_xl,
    input  logic [PG_W-1:0]  cfg_tbl_pg,
    input  logic             up_valid,
    input  logic [IA_W-1:0]  up_addr,
    output logic             up_ready,
    output logic [IA_W-1:0]  cap_addr,
    input  logic             below,
    input  logic [WIN_W-1:0] win,
    input  logic [IDX_W-1:0] idx,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [PA_W-1:0]  dn_addr,
    output logic             fault,
    output logic             idle
);
    lpt_state_e       st, st_nx;
    logic [IA_W-1:0]  cap_q;
    logic [PG_W-1:0]  cur_pg;
    logic [PG_W-1:0]  hit_pg;
    logic [WIN_W-1:0] cur_win;
    logic             warm;
    logic             go_up;
    logic             rd_ok;
    logic             unused_rd;

    assign rd_ok     = mem_rdata[0];
    assign unused_rd = ^mem_rdata;
    assign cap_addr  = cap_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_OFF;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_OFF:   if (cfg_en) st_nx = S_WAIT;
            S_WAIT:  begin
                if (!cfg_en)       st_nx = S_OFF;
                else if (up_valid) st_nx = S_CHK;
            end
            S_CHK:   begin
                if (!cfg_xl)    st_nx = S_SEND;
                else if (below) st_nx = S_FAULT;
                else            st_nx = S_WALK;
            end
            S_WALK:  st_nx = (win == cur_win) ? S_EREQ : S_LREQ;
            S_LREQ:  st_nx = S_LWAIT;
            S_LWAIT: if (mem_rvalid) st_nx = rd_ok ? S_WALK : S_FAULT;
            S_EREQ:  st_nx = S_EWAIT;
            S_EWAIT: if (mem_rvalid) st_nx = rd_ok ? S_SEND : S_FAULT;
            S_SEND:  if (dn_ready) st_nx = S_WAIT;
            S_FAULT: st_nx = S_WAIT;
            default: st_nx = S_OFF;
        endcase
    end

    // walk position and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q   <= '0;
            cur_pg  <= '0;
            hit_pg  <= '0;
            cur_win <= '0;
            warm    <= 1'b0;
            go_up   <= 1'b0;
        end else begin
            case (st)
                S_OFF:   warm <= 1'b0;
                S_WAIT:  if (cfg_en && up_valid) cap_q <= up_addr;
                S_CHK:   begin
                    if (cfg_xl && !below && !warm) begin
                        cur_pg  <= cfg_tbl_pg;
                        cur_win <= '0;
                        warm    <= 1'b1;
                    end
                end
                S_WALK:  go_up <= win > cur_win;
                S_LWAIT: begin
                    if (mem_rvalid && rd_ok) begin
                        cur_pg  <= mem_rdata[PA_W-1:PG_SH];
                        cur_win <= go_up ? cur_win + 1'b1 : cur_win - 1'b1;
                    end
                end
                S_EWAIT: if (mem_rvalid) hit_pg <= mem_rdata[PA_W-1:PG_SH];
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        up_ready = (st == S_SEND && dn_ready) || st == S_FAULT;
        dn_valid = st == S_SEND;
        dn_addr  = cfg_xl ? {hit_pg, cap_q[PG_SH-1:0]} : PA_W'(cap_q);
        mem_req  = st == S_LREQ || st == S_EREQ;
        if (st == S_LREQ) mem_addr = {cur_pg, go_up ? SLOT_NEXT : SLOT_PREV, 3'b000};
        else              mem_addr = {cur_pg, 1'b0, idx, 3'b000};
        fault    = st == S_FAULT;
        idle     = st == S_OFF;
    end
endmodule

// File: rtl/lpt_xlat.sv
module lpt_xlat
    import lpt_pkg::*;
#(
    parameter int IA_W   = 32,
    parameter int PA_W   = 40,
    parameter int DATA_W = 32,
    parameter int REG_W  = 64,
    localparam int WIN_W = IA_W - WIN_SH,
    localparam int PG_W  = PA_W - PG_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [IA_W-1:0]   up_addr,
    input  logic [DATA_W-1:0] up_data,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [PA_W-1:0]   dn_addr,
    output logic [DATA_W-1:0] dn_data,
    output logic              xl_fault
);
    logic             cfg_en;
    logic             cfg_xl;
    logic [WIN_W-1:0] cfg_base_hi;
    logic [PG_W-1:0]  cfg_tbl_pg;
    logic             sts_err;
    logic             fsm_idle;
    logic [IA_W-1:0]  cap_addr;
    logic             below;
    logic [WIN_W-1:0] win;
    logic [IDX_W-1:0] idx;

    assign dn_data = up_data;

    lpt_regs #(.IA_W(IA_W), .PA_W(PA_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fsm_idle(fsm_idle), .fault_set(xl_fault),
        .cfg_en(cfg_en), .cfg_xl(cfg_xl), .cfg_base_hi(cfg_base_hi),
        .cfg_tbl_pg(cfg_tbl_pg), .sts_err(sts_err)
    );

    lpt_window #(.IA_W(IA_W)) u_win (
        .in_addr(cap_addr), .base_hi(cfg_base_hi),
        .below(below), .win(win), .idx(idx)
    );

    lpt_fsm #(.IA_W(IA_W), .PA_W(PA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_xl(cfg_xl), .cfg_tbl_pg(cfg_tbl_pg),
        .up_valid(up_valid), .up_addr(up_addr), .up_ready(up_ready),
        .cap_addr(cap_addr), .below(below), .win(win), .idx(idx),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
        .fault(xl_fault), .idle(fsm_idle)
    );
endmodule

// File: rtl/lpt_chk.sv
module lpt_chk
    import lpt_pkg::*;
#(
    parameter int IA_W  = 32,
    parameter int PA_W  = 40,
    parameter int REG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic             up_ready,
    input logic [IA_W-1:0]  up_addr,
    input logic             mem_req,
    input logic             mem_rvalid,
    input logic             dn_valid,
    input logic             dn_ready,
    input logic [PA_W-1:0]  dn_addr,
    input logic             xl_fault,
    input logic             fsm_idle,
    input logic             cfg_xl,
    input logic             sts_err
);
    logic pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend <= 1'b0;
        else if (mem_req)    pend <= 1'b1;
        else if (mem_rvalid) pend <= 1'b0;
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pend); // R13

    AST_PASS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !cfg_xl) |-> dn_addr == PA_W'(up_addr)); // R2

    AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr))); // R3

    AST_FAULT_NO_DN: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> (!dn_valid && up_ready)); // R7

    AST_FAULT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |=> sts_err); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_err && !(reg_wr && reg_addr == RA_STAT && reg_wdata[1])) |=> sts_err); // R10

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_MODE && !fsm_idle) |=> $stable(cfg_xl)); // R11

    AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> (!pend && !dn_valid)); // R12
endmodule

bind lpt_xlat lpt_chk #(.IA_W(IA_W), .PA_W(PA_W), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .up_ready(up_ready), .up_addr(up_addr), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .xl_fault(xl_fault),
    .fsm_idle(fsm_idle), .cfg_xl(cfg_xl), .sts_err(sts_err)
);

// File: tb/lpt_xlat_tb.sv
module lpt_xlat_tb;
    localparam int IA_W = 32, PA_W = 40, DATA_W = 32, REG_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              up_valid = 1'b0;
    logic              up_ready;
    logic [IA_W-1:0]   up_addr = '0;
    logic [DATA_W-1:0] up_data = '0;
    logic              mem_req;
    logic [PA_W-1:0]   mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [63:0]       mem_rdata = '0;
    logic              dn_valid;
    logic              dn_ready = 1'b1;
    logic [PA_W-1:0]   dn_addr;
    logic [DATA_W-1:0] dn_data;
    logic              xl_fault;

    always #5 clk = ~clk;

    lpt_xlat #(.IA_W(IA_W), .PA_W(PA_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_data(up_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_data(dn_data),
        .xl_fault(xl_fault)
    );

    int checks = 0;
    int errs = 0;

    logic [63:0]       mem [longint];
    logic [PA_W-1:0]   exp_rd[$];
    string             rd_tag[$];
    bit                exp_flt[$];
    logic [PA_W-1:0]   exp_pa[$];
    logic [DATA_W-1:0] exp_dat[$];
    string             exp_tag[$];

    int                rcnt = 0;
    logic [PA_W-1:0]   rd_at = '0;
    logic [PA_W-1:0]   e_rd;
    string             e_rt;
    bit                p_f;
    logic [PA_W-1:0]   p_pa;
    logic [DATA_W-1:0] p_d;
    string             p_t;

    localparam logic [PA_W-1:0] T0 = 40'h01_0000_0000;
    localparam logic [PA_W-1:0] T1 = 40'h01_0000_3000;
    localparam logic [PA_W-1:0] T2 = 40'h01_0000_7000;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_val(input logic [PA_W-1:0] a);
        return mem.exists(longint'(a)) ? mem[longint'(a)] : 64'd0;
    endfunction

    // memory model: compares each table read against the expected list, answers two cycles later
    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            if (exp_rd.size() == 0) begin
                chk(1'b0, "R13 unexpected table read", 64'(mem_addr), 64'd0);
            end else begin
                e_rd = exp_rd.pop_front();
                e_rt = rd_tag.pop_front();
                chk(mem_addr == e_rd, {e_rt, " table read address"}, 64'(mem_addr), 64'(e_rd));
            end
            rd_at <= mem_addr;
            rcnt  <= 2;
        end else if (rcnt == 2) begin
            rcnt <= 1;
        end else if (rcnt == 1) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem_val(rd_at);
            rcnt       <= 0;
        end
    end

    // monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if ((dn_valid && dn_ready) || xl_fault) begin
            if (exp_flt.size() == 0) begin
                chk(1'b0, "R7 result with nothing expected", 64'(dn_addr), 64'd0);
            end else begin
                p_f  = exp_flt.pop_front();
                p_pa = exp_pa.pop_front();
                p_d  = exp_dat.pop_front();
                p_t  = exp_tag.pop_front();
                if (xl_fault) begin
                    chk(p_f && !dn_valid, {p_t, " fault outcome"}, 64'(dn_valid), 64'(0));
                end else begin
                    chk(!p_f, {p_t, " expected fault, got downstream"}, 64'(1), 64'(0));
                    chk(dn_addr == p_pa, {p_t, " dn_addr"}, 64'(dn_addr), 64'(p_pa));
                    chk(dn_data == p_d, {p_t, " dn_data"}, 64'(dn_data), 64'(p_d));
                end
            end
        end
    end

    task automatic er(input logic [PA_W-1:0] a, input string tag);
        exp_rd.push_back(a);
        rd_tag.push_back(tag);
    endtask

    task automatic xfer(input logic [IA_W-1:0] a, input logic [DATA_W-1:0] d,
                        input bit f, input logic [PA_W-1:0] pa, input string tag);
        exp_flt.push_back(f);
        exp_pa.push_back(pa);
        exp_dat.push_back(d);
        exp_tag.push_back(tag);
        @(negedge clk);
        up_valid = 1'b1;
        up_addr  = a;
        up_data  = d;
        do @(negedge clk); while (!up_ready);
        @(negedge clk);
        up_valid = 1'b0;
        chk(exp_rd.size() == 0, {tag, " all table reads made"}, 64'(exp_rd.size()), 64'd0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [REG_W-1:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        logic [REG_W-1:0] v;

        // table chain: T0 <-> T1 <-> T2
        for (int i = 0; i < 4; i++) mem[longint'(T0 + 8 * i)] = 64'h02_0000_0000 + 64'(i * 4096) + 64'd1;
        mem[longint'(T0 + 40'hFF8)] = 64'(T1) | 64'd1;
        mem[longint'(T1 + 40'hFF0)] = 64'(T0) | 64'd1;
        mem[longint'(T1 + 40'hFF8)] = 64'(T2) | 64'd1;
        mem[longint'(T1 + 40'h100)] = 64'h03_0000_5001;
        mem[longint'(T2 + 40'hFF0)] = 64'(T1) | 64'd1;
        mem[longint'(T2 + 40'h008)] = 64'h04_1234_5001;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd2, v); chk(v == 64'd1, "R1 status after reset", v, 64'd1);
        rd(3'd0, v); chk(v == 64'd0, "R1 control after reset", v, 64'd0);
        chk(!dn_valid && !mem_req && !xl_fault, "R1 outputs quiet", 64'({dn_valid, mem_req, xl_fault}), 64'd0);

        // pass-through
        wr(3'd3, 64'h0010_0000);
        wr(3'd4, 64'(T0));
        wr(3'd1, 64'd0);
        wr(3'd0, 64'd1);
        rd(3'd2, v); chk(v[0] == 1'b0, "R12 not ready while enabled", 64'(v[0]), 64'd0);
        wr(3'd1, 64'd1);
        rd(3'd1, v); chk(v == 64'd0, "R11 mode write ignored while enabled", v, 64'd0);
        xfer(32'h1234_5678, 32'hA5A5_0001, 1'b0, 40'h00_1234_5678, "R2 pass high");
        xfer(32'h0000_0ABC, 32'hA5A5_0002, 1'b0, 40'h00_0000_0ABC, "R2 pass below base");
        wr(3'd0, 64'd0);
        repeat (3) @(negedge clk);
        rd(3'd2, v); chk(v == 64'd1, "R12 ready after disable", v, 64'd1);

        // translate
        wr(3'd1, 64'd1);
        rd(3'd1, v); chk(v == 64'd1, "R11 mode write taken while stopped", v, 64'd1);
        wr(3'd0, 64'd1);
        wr(3'd3, 64'h0F00_0000);
        rd(3'd3, v); chk(v == 64'h0010_0000, "R11 base write ignored while enabled", v, 64'h0010_0000);

        er(T0 + 40'h000, "R3");
        xfer(32'h0010_0ABC, 32'h1111_0001, 1'b0, 40'h02_0000_0ABC, "R3 window0 idx0");
        er(T0 + 40'h018, "R6");
        xfer(32'h0010_3FFC, 32'h1111_0002, 1'b0, 40'h02_0000_3FFC, "R6 cached window idx3");
        er(T0 + 40'hFF8, "R4"); er(T1 + 40'h100, "R4");
        xfer(32'h0022_0010, 32'h1111_0003, 1'b0, 40'h03_0000_5010, "R4 step to window1");
        er(T1 + 40'hFF8, "R4"); er(T2 + 40'h008, "R4");
        xfer(32'h0030_1008, 32'h1111_0004, 1'b0, 40'h04_1234_5008, "R4 step to window2");
        er(T2 + 40'hFF0, "R5"); er(T1 + 40'hFF0, "R5"); er(T0 + 40'h000, "R5");
        xfer(32'h0010_0004, 32'h1111_0005, 1'b0, 40'h02_0000_0004, "R5 descend to window0");

        // faults and sticky error
        er(T0 + 40'h028, "R7");
        xfer(32'h0010_5000, 32'h2222_0001, 1'b1, '0, "R7 invalid entry");
        rd(3'd2, v); chk(v[1] == 1'b1, "R7 error flag set", 64'(v[1]), 64'd1);
        wr(3'd2, 64'd0);
        rd(3'd2, v); chk(v[1] == 1'b1, "R10 writing zero keeps error", 64'(v[1]), 64'd1);
        wr(3'd2, 64'd2);
        rd(3'd2, v); chk(v[1] == 1'b0, "R10 writing one clears error", 64'(v[1]), 64'd0);
        er(T0 + 40'hFF8, "R8"); er(T1 + 40'hFF8, "R8"); er(T2 + 40'hFF8, "R8");
        xfer(32'h0040_0000, 32'h2222_0002, 1'b1, '0, "R8 invalid link");
        rd(3'd2, v); chk(v[1] == 1'b1, "R8 error flag set", 64'(v[1]), 64'd1);
        wr(3'd2, 64'd2);
        xfer(32'h0000_1000, 32'h2222_0003, 1'b1, '0, "R9 below base");
        rd(3'd2, v); chk(v[1] == 1'b1, "R9 error flag set", 64'(v[1]), 64'd1);

        // drain on disable: position left at T2 window2 by the failed walk
        er(T2 + 40'h008, "R12");
        fork
            xfer(32'h0030_1008, 32'h3333_0001, 1'b0, 40'h04_1234_5008, "R12 drain request");
            begin
                repeat (2) @(negedge clk);
                wr(3'd0, 64'd0);
                rd(3'd2, v); chk(v[0] == 1'b0, "R12 busy during drain", 64'(v[0]), 64'd0);
            end
        join
        repeat (3) @(negedge clk);
        rd(3'd2, v); chk(v[0] == 1'b1, "R12 ready after drain", 64'(v[0]), 64'd1);

        // re-enable restarts from the table base
        wr(3'd0, 64'd1);
        er(T0 + 40'hFF8, "R6"); er(T1 + 40'h100, "R6");
        xfer(32'h0022_0010, 32'h4444_0001, 1'b0, 40'h03_0000_5010, "R6 reload after enable");

        repeat (4) @(negedge clk);
        chk(exp_flt.size() == 0, "R7 all results seen", 64'(exp_flt.size()), 64'd0);
        chk(exp_rd.size() == 0, "R13 no reads left", 64'(exp_rd.size()), 64'd0);
        summary();
        $finish;
    end
endmodule